// File: doc/BRIEF.md
# Configurable Snooping Coherence Line Controller

This block keeps the coherence state of every line in a snooping-bus cache and decides what each event does to it. Three kinds of event arrive on a shared set of inputs: a request from the local processor, a response that completes the local cache's own bus transaction, and a command snooped from another agent on the bus. A one-hot select chooses the kind of event, and a line index chooses the line. The block looks up the line's stored state, works out the transition, writes the new state back, and reports the bus command to issue, whether to supply data, whether to drive the shared line, and whether the event was illegal for that state.

One transition table serves four protocol variants. The `PROTO` parameter picks MSI, MESI, MOSI or MOESI at elaboration, and `UPGRADES` enables upgrade transactions. A state is three bits: valid, writable and dirty. The Owned state lets a dirty line keep supplying data to readers without a write-back. Elaboration is refused for an ownership variant with upgrades disabled. In that combination a write to an Owned line would fetch exclusive data from memory and lose the dirty copy.

Top module: `coh_line_ctrl`

## Requirements
- R1: State bits are [2]=valid, [1]=writable, [0]=dirty. Modified=111, Owned=101, Exclusive=110, Shared=100, Invalid=000. Reset clears every line to Invalid and clears all outputs.
- R2: Local command codes are 0 read, 1 write, 2 software prefetch and 3 hardware prefetch. Bus command codes are 0 none, 1 read, 2 read-exclusive and 3 upgrade. On an Invalid line, a read or either prefetch issues a read and a write issues a read-exclusive. A write on Shared or Owned issues an upgrade when upgrades are enabled and a read-exclusive otherwise. The state does not change in any of these cases.
- R3: A local read on any valid line, or a local write on Modified, issues no bus command and leaves the state unchanged. A local write on Exclusive moves the line to Modified with no bus command.
- R4: Response codes are 0 read, 1 read-exclusive and 2 upgrade. A read response on Invalid gives Exclusive when the protocol has Exclusive and the shared sample is low, and Shared otherwise. A read-exclusive response on Invalid gives Modified. On Shared or Owned, an upgrade response (upgrades enabled) or a read-exclusive response (upgrades disabled) gives Modified.
- R5: Snoop codes are 0 read, 1 read-exclusive, 2 upgrade, 3 invalidate and 4 write-invalidate. A snooped read on Shared or Exclusive asserts the shared line in MESI/MOESI, and Exclusive moves to Shared in that same operation. In MSI/MOSI a Shared line does nothing on a snooped read. An Invalid line ignores snooped reads and read-exclusives, and also upgrades when upgrades are enabled.
- R6: A snooped read-exclusive on Shared or Exclusive, or a snooped upgrade on Shared (upgrades enabled), moves the line to Invalid without supplying data.
- R7: A snooped read on Modified supplies data and moves to Owned if the protocol has it, otherwise to Shared. A snooped read-exclusive on Modified supplies data and moves to Invalid.
- R8: On an Owned line, a snooped read supplies data and stays Owned. A snooped read-exclusive supplies data and invalidates. A snooped upgrade invalidates without supplying data.
- R9: A snooped invalidate or write-invalidate moves any state to Invalid without supplying data.
- R10: Every other pair of state and command raises `illegal` for one cycle, with no bus command, no supply and no shared assert, and leaves the state unchanged. This covers a prefetch on a valid line, a mismatched response, response code 3, snoop codes 5 to 7, and any upgrade command or response with upgrades disabled.
- R11: op_sel bit 0 selects a local request, bit 1 a response and bit 2 a snoop. When several bits are set, snoop wins over response, and response wins over local; the losing events are ignored. Results and `line_state` (the addressed line's new state) register on the next rising edge. A cycle with no operation leaves the bus command, supply, shared and illegal outputs low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | One-hot operation select: [0] local, [1] response, [2] snoop |
| line_idx | input | IDX_W | Line addressed by the operation |
| loc_cmd | input | 2 | Local request code |
| rsp_cmd | input | 2 | Response code |
| rsp_shared | input | 1 | Shared line as sampled during the completed transaction |
| snp_cmd | input | 3 | Snooped bus command code |
| bus_cmd | output | 2 | Bus command to issue |
| supply_data | output | 1 | This cache must supply the line's data |
| assert_shared | output | 1 | Drive the bus shared line |
| illegal | output | 1 | Operation not legal for the line's state |
| line_state | output | 3 | New state of the addressed line |

## Verification
A snoop and a local request, or a snoop and a response, can reach the same line in the same cycle. The bench provokes this by setting two select bits together on one line. For example, a local write and a snooped read on a Modified line are sent together. The result is judged correct only if the outputs match the snoop alone: data supplied, state moved to Owned or Shared, and no bus command left over from the local write. A response paired with a local write on an Invalid line must likewise complete the fill to Modified and must not issue the local write's read-exclusive.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef logic [2:0] lstate_t;
  localparam lstate_t ST_I = 3'b000;
  localparam lstate_t ST_S = 3'b100;
  localparam lstate_t ST_E = 3'b110;
  localparam lstate_t ST_O = 3'b101;
  localparam lstate_t ST_M = 3'b111;

  typedef enum logic [1:0] {BUS_NONE = 2'd0, BUS_RD = 2'd1, BUS_RDX = 2'd2, BUS_UPG = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {LOC_RD = 2'd0, LOC_WR = 2'd1, LOC_SWPF = 2'd2, LOC_HWPF = 2'd3} loc_cmd_e;
  typedef enum logic [1:0] {RSP_RD = 2'd0, RSP_RDX = 2'd1, RSP_UPG = 2'd2, RSP_BAD = 2'd3} rsp_cmd_e;
  typedef enum logic [2:0] {SNP_RD = 3'd0, SNP_RDX = 3'd1, SNP_UPG = 3'd2, SNP_INV = 3'd3,
                            SNP_WINV = 3'd4} snp_cmd_e;
  typedef enum logic [1:0] {OP_NONE, OP_LOC, OP_RSP, OP_SNP} op_e;

  localparam int PROTO_MSI   = 0;
  localparam int PROTO_MESI  = 1;
  localparam int PROTO_MOSI  = 2;
  localparam int PROTO_MOESI = 3;
endpackage

// File: rtl/coh_op_pick.sv
module coh_op_pick
  import coh_pkg::*;
(
  input  logic [2:0] op_sel,
  output op_e        op
);
  always_comb begin
    if (op_sel[2])      op = OP_SNP;
    else if (op_sel[1]) op = OP_RSP;
    else if (op_sel[0]) op = OP_LOC;
    else                op = OP_NONE;
  end
endmodule

// File: rtl/coh_state_file.sv
module coh_state_file #(
  parameter int LINES = 16,
  parameter int SW    = 3,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [SW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [SW-1:0]    rdata
);
  logic [SW-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/coh_xition.sv
module coh_xition
  import coh_pkg::*;
#(
  parameter int PROTO    = PROTO_MOESI,
  parameter bit UPGRADES = 1'b1
) (
  input  op_e      op,
  input  lstate_t  cur,
  input  loc_cmd_e loc_cmd,
  input  rsp_cmd_e rsp_cmd,
  input  logic     rsp_shared,
  input  snp_cmd_e snp_cmd,
  output lstate_t  nxt,
  output bus_cmd_e bus,
  output logic     supply,
  output logic     shared,
  output logic     err
);
  localparam bit HAS_E = (PROTO == PROTO_MESI) || (PROTO == PROTO_MOESI);
  localparam bit HAS_O = (PROTO == PROTO_MOSI) || (PROTO == PROTO_MOESI);

  lstate_t st;
  logic    st_ok;
  lstate_t n;
  bus_cmd_e b;
  logic    sp, sh, e;

  assign st = cur & ST_M;   // only valid/writable/dirty take part

  always_comb begin
    unique case (st)
      ST_I, ST_S, ST_M: st_ok = 1'b1;
      ST_E:             st_ok = HAS_E;
      ST_O:             st_ok = HAS_O;
      default:          st_ok = 1'b0;
    endcase
  end

  always_comb begin
    n  = st;
    b  = BUS_NONE;
    sp = 1'b0;
    sh = 1'b0;
    e  = 1'b0;
    if (op != OP_NONE && !st_ok) begin
      e = 1'b1;
    end else begin
      case (op)
        OP_LOC: begin
          case (loc_cmd)
            LOC_RD: if (st == ST_I) b = BUS_RD;
            LOC_WR: begin
              if (st == ST_I) b = BUS_RDX;
              else if (st == ST_S || st == ST_O) b = UPGRADES ? BUS_UPG : BUS_RDX;
              else if (st == ST_E) n = ST_M;
            end
            default: begin
              if (st == ST_I) b = BUS_RD;
              else            e = 1'b1;
            end
          endcase
        end
        OP_RSP: begin
          case (rsp_cmd)
            RSP_RD: begin
              if (st == ST_I) n = (HAS_E && !rsp_shared) ? ST_E : ST_S;
              else            e = 1'b1;
            end
            RSP_RDX: begin
              if (st == ST_I) n = ST_M;
              else if (!UPGRADES && (st == ST_S || st == ST_O)) n = ST_M;
              else e = 1'b1;
            end
            RSP_UPG: begin
              if (UPGRADES && (st == ST_S || st == ST_O)) n = ST_M;
              else e = 1'b1;
            end
            default: e = 1'b1;
          endcase
        end
        OP_SNP: begin
          case (snp_cmd)
            SNP_RD: begin
              case (st)
                ST_S: sh = HAS_E;
                ST_E: begin sh = 1'b1; n = ST_S; end
                ST_M: begin sp = 1'b1; n = HAS_O ? ST_O : ST_S; end
                ST_O: sp = 1'b1;
                default: ;
              endcase
            end
            SNP_RDX: begin
              if (st == ST_M || st == ST_O) sp = 1'b1;
              n = ST_I;
            end
            SNP_UPG: begin
              if (st == ST_O) n = ST_I;
              else if (UPGRADES && st == ST_S) n = ST_I;
              else if (!(UPGRADES && st == ST_I)) e = 1'b1;
            end
            SNP_INV, SNP_WINV: n = ST_I;
            default: e = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    nxt    = e ? st : n;
    bus    = e ? BUS_NONE : b;
    supply = sp && !e;
    shared = sh && !e;
    err    = e;
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int LINES    = 16,
  parameter int PROTO    = PROTO_MOESI,
  parameter bit UPGRADES = 1'b1,
  localparam int IDX_W   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_sel,
  input  logic [IDX_W-1:0] line_idx,
  input  logic [1:0]       loc_cmd,
  input  logic [1:0]       rsp_cmd,
  input  logic             rsp_shared,
  input  logic [2:0]       snp_cmd,
  output logic [1:0]       bus_cmd,
  output logic             supply_data,
  output logic             assert_shared,
  output logic             illegal,
  output logic [2:0]       line_state
);
  generate
    if (PROTO < PROTO_MSI || PROTO > PROTO_MOESI) begin : g_bad_proto
      $fatal(1, "coh_line_ctrl: PROTO out of range");
    end
    if ((PROTO == PROTO_MOSI || PROTO == PROTO_MOESI) && !UPGRADES) begin : g_bad_cfg
      $fatal(1, "coh_line_ctrl: owned-state protocols need upgrade transactions");
    end
  endgenerate

  op_e      op;
  lstate_t  cur_st;
  lstate_t  nxt_st;
  bus_cmd_e x_bus;
  logic     x_sup, x_shr, x_err;

  coh_op_pick u_pick (
    .op_sel (op_sel),
    .op     (op)
  );

  coh_state_file #(.LINES(LINES), .SW(3)) u_states (
    .clk   (clk),
    .rst   (rst),
    .we    (op != OP_NONE),
    .waddr (line_idx),
    .wdata (nxt_st),
    .raddr (line_idx),
    .rdata (cur_st)
  );

  coh_xition #(.PROTO(PROTO), .UPGRADES(UPGRADES)) u_xition (
    .op         (op),
    .cur        (cur_st),
    .loc_cmd    (loc_cmd_e'(loc_cmd)),
    .rsp_cmd    (rsp_cmd_e'(rsp_cmd)),
    .rsp_shared (rsp_shared),
    .snp_cmd    (snp_cmd_e'(snp_cmd)),
    .nxt        (nxt_st),
    .bus        (x_bus),
    .supply     (x_sup),
    .shared     (x_shr),
    .err        (x_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cmd       <= BUS_NONE;
      supply_data   <= 1'b0;
      assert_shared <= 1'b0;
      illegal       <= 1'b0;
      line_state    <= ST_I;
    end else begin
      bus_cmd       <= (op != OP_NONE) ? x_bus : BUS_NONE;
      supply_data   <= (op != OP_NONE) && x_sup;
      assert_shared <= (op != OP_NONE) && x_shr;
      illegal       <= (op != OP_NONE) && x_err;
      if (op != OP_NONE) line_state <= nxt_st;
    end
  end
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] op_sel,
  input logic [2:0] snp_cmd,
  input logic [1:0] bus_cmd,
  input logic       supply_data,
  input logic       assert_shared,
  input logic       illegal,
  input logic [2:0] line_state
);
  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (bus_cmd == 2'd0 && !supply_data && !assert_shared));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b000) |=> (bus_cmd == 2'd0 && !supply_data && !assert_shared && !illegal));

  // R11
  snoop_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    op_sel[2] |=> (bus_cmd == 2'd0));

  // R7
  supply_from_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    supply_data |-> (!assert_shared && $past(op_sel[2])));

  // R9
  inval_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b100 && (snp_cmd == 3'd3 || snp_cmd == 3'd4))
      |=> (line_state == 3'b000 && !supply_data && !illegal));

  // R2
  upg_from_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd3) |-> line_state[2]);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .op_sel        (op_sel),
  .snp_cmd       (snp_cmd),
  .bus_cmd       (bus_cmd),
  .supply_data   (supply_data),
  .assert_shared (assert_shared),
  .illegal       (illegal),
  .line_state    (line_state)
);

// File: tb/test_coh_line_ctrl.sv
`timescale 1ns/1ps
module test_coh_line_ctrl;
  localparam logic [2:0] I = 3'b000, S = 3'b100, E = 3'b110, O = 3'b101, M = 3'b111;
  localparam logic [2:0] L = 3'b001, R = 3'b010, N = 3'b100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_sel = '0;
  logic [3:0] line_idx = '0;
  logic [1:0] loc_cmd = '0;
  logic [1:0] rsp_cmd = '0;
  logic       rsp_shared = 1'b0;
  logic [2:0] snp_cmd = '0;

  logic [1:0] bus_a, bus_b;
  logic       sup_a, sup_b, shr_a, shr_b, ill_a, ill_b;
  logic [2:0] st_a, st_b;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  // MOESI with upgrades
  coh_line_ctrl #(.LINES(16), .PROTO(3), .UPGRADES(1'b1)) i_coh_line_ctrl (
    .clk(clk), .rst(rst), .op_sel(op_sel), .line_idx(line_idx), .loc_cmd(loc_cmd),
    .rsp_cmd(rsp_cmd), .rsp_shared(rsp_shared), .snp_cmd(snp_cmd),
    .bus_cmd(bus_a), .supply_data(sup_a), .assert_shared(shr_a), .illegal(ill_a),
    .line_state(st_a));

  // MSI without upgrades
  coh_line_ctrl #(.LINES(16), .PROTO(0), .UPGRADES(1'b0)) i_coh_line_ctrl_msi (
    .clk(clk), .rst(rst), .op_sel(op_sel), .line_idx(line_idx), .loc_cmd(loc_cmd),
    .rsp_cmd(rsp_cmd), .rsp_shared(rsp_shared), .snp_cmd(snp_cmd),
    .bus_cmd(bus_b), .supply_data(sup_b), .assert_shared(shr_b), .illegal(ill_b),
    .line_state(st_b));

  function automatic logic [7:0] pk(input logic ill, input logic shr, input logic sup,
                                    input logic [1:0] bus, input logic [2:0] st);
    return {ill, shr, sup, bus, st};
  endfunction

  task automatic check(input string tag, input string dut, input logic [7:0] got,
                       input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s dut=%s got ill/shr/sup/bus/st=%b expected=%b", tag, dut, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic [2:0] sel, input int idx,
                      input logic [1:0] lc, input logic [1:0] rc, input logic rs,
                      input logic [2:0] sc, input logic [7:0] ea, input logic [7:0] eb);
    @(negedge clk);
    op_sel = sel; line_idx = 4'(idx); loc_cmd = lc; rsp_cmd = rc; rsp_shared = rs; snp_cmd = sc;
    @(negedge clk);
    op_sel = '0;
    check(tag, "moesi", {ill_a, shr_a, sup_a, bus_a, st_a}, ea);
    check(tag, "msi",   {ill_b, shr_b, sup_b, bus_b, st_b}, eb);
  endtask

  task automatic t_reset;
    check("R1 reset", "moesi", {ill_a, shr_a, sup_a, bus_a, st_a}, 8'h00);
    check("R1 reset", "msi",   {ill_b, shr_b, sup_b, bus_b, st_b}, 8'h00);
    step("R1 line0 invalid after reset", L, 0, 2'd0, 0, 0, 0, pk(0,0,0,2'd1,I), pk(0,0,0,2'd1,I));
  endtask

  task automatic t_miss_fill;
    step("R2 write miss", L, 1, 2'd1, 0, 0, 0, pk(0,0,0,2'd2,I), pk(0,0,0,2'd2,I));
    step("R4 rdx fill", R, 1, 0, 2'd1, 0, 0, pk(0,0,0,0,M), pk(0,0,0,0,M));
    step("R2 sw prefetch", L, 2, 2'd2, 0, 0, 0, pk(0,0,0,2'd1,I), pk(0,0,0,2'd1,I));
    step("R4 read fill unshared", R, 2, 0, 2'd0, 0, 0, pk(0,0,0,0,E), pk(0,0,0,0,S));
    step("R2 hw prefetch", L, 3, 2'd3, 0, 0, 0, pk(0,0,0,2'd1,I), pk(0,0,0,2'd1,I));
    step("R4 read fill shared", R, 3, 0, 2'd0, 1, 0, pk(0,0,0,0,S), pk(0,0,0,0,S));
  endtask

  task automatic t_hits;
    step("R3 read hit", L, 2, 2'd0, 0, 0, 0, pk(0,0,0,0,E), pk(0,0,0,0,S));
    step("R3 R2 write E silent / S rdx", L, 2, 2'd1, 0, 0, 0, pk(0,0,0,0,M), pk(0,0,0,2'd2,S));
    step("R10 R4 rdx resp on M / on S", R, 2, 0, 2'd1, 0, 0, pk(1,0,0,0,M), pk(0,0,0,0,M));
    step("R3 write hit M", L, 1, 2'd1, 0, 0, 0, pk(0,0,0,0,M), pk(0,0,0,0,M));
  endtask

  task automatic t_dirty_snoop;
    step("R7 snoop read on M", N, 2, 0, 0, 0, 3'd0, pk(0,0,1,0,O), pk(0,0,1,0,S));
    step("R2 write on O / S", L, 2, 2'd1, 0, 0, 0, pk(0,0,0,2'd3,O), pk(0,0,0,2'd2,S));
    step("R4 R10 upgrade resp", R, 2, 0, 2'd2, 0, 0, pk(0,0,0,0,M), pk(1,0,0,0,S));
    step("R7 snoop read M again", N, 2, 0, 0, 0, 3'd0, pk(0,0,1,0,O), pk(0,0,0,0,S));
    step("R8 R10 snoop upgrade O", N, 2, 0, 0, 0, 3'd2, pk(0,0,0,0,I), pk(1,0,0,0,S));
  endtask

  task automatic t_clean_snoop;
    step("R5 snoop read on S", N, 3, 0, 0, 0, 3'd0, pk(0,1,0,0,S), pk(0,0,0,0,S));
    step("R6 R10 snoop upgrade S", N, 3, 0, 0, 0, 3'd2, pk(0,0,0,0,I), pk(1,0,0,0,S));
    step("R5 R6 snoop rdx I / S", N, 3, 0, 0, 0, 3'd1, pk(0,0,0,0,I), pk(0,0,0,0,I));
    step("R5 snoop upgrade on I", N, 3, 0, 0, 0, 3'd2, pk(0,0,0,0,I), pk(1,0,0,0,I));
    step("R2 prefetch line4", L, 4, 2'd2, 0, 0, 0, pk(0,0,0,2'd1,I), pk(0,0,0,2'd1,I));
    step("R4 fill line4", R, 4, 0, 2'd0, 0, 0, pk(0,0,0,0,E), pk(0,0,0,0,S));
    step("R5 snoop read on E", N, 4, 0, 0, 0, 3'd0, pk(0,1,0,0,S), pk(0,0,0,0,S));
  endtask

  task automatic t_owned;
    step("R2 write line5", L, 5, 2'd1, 0, 0, 0, pk(0,0,0,2'd2,I), pk(0,0,0,2'd2,I));
    step("R4 fill line5", R, 5, 0, 2'd1, 0, 0, pk(0,0,0,0,M), pk(0,0,0,0,M));
    step("R7 snoop read line5", N, 5, 0, 0, 0, 3'd0, pk(0,0,1,0,O), pk(0,0,1,0,S));
    step("R8 snoop read on O stays", N, 5, 0, 0, 0, 3'd0, pk(0,0,1,0,O), pk(0,0,0,0,S));
    step("R8 R6 snoop rdx O / S", N, 5, 0, 0, 0, 3'd1, pk(0,0,1,0,I), pk(0,0,0,0,I));
    step("R2 write line8", L, 8, 2'd1, 0, 0, 0, pk(0,0,0,2'd2,I), pk(0,0,0,2'd2,I));
    step("R4 fill line8", R, 8, 0, 2'd1, 0, 0, pk(0,0,0,0,M), pk(0,0,0,0,M));
    step("R7 snoop rdx on M", N, 8, 0, 0, 0, 3'd1, pk(0,0,1,0,I), pk(0,0,1,0,I));
  endtask

  task automatic t_invalidate;
    step("R2 write line6", L, 6, 2'd1, 0, 0, 0, pk(0,0,0,2'd2,I), pk(0,0,0,2'd2,I));
    step("R4 fill line6", R, 6, 0, 2'd1, 0, 0, pk(0,0,0,0,M), pk(0,0,0,0,M));
    step("R9 write-invalidate on M", N, 6, 0, 0, 0, 3'd4, pk(0,0,0,0,I), pk(0,0,0,0,I));
    step("R9 invalidate on I", N, 7, 0, 0, 0, 3'd3, pk(0,0,0,0,I), pk(0,0,0,0,I));
    step("R9 invalidate on S", N, 4, 0, 0, 0, 3'd3, pk(0,0,0,0,I), pk(0,0,0,0,I));
  endtask

  task automatic t_illegal;
    step("R10 prefetch on M", L, 1, 2'd3, 0, 0, 0, pk(1,0,0,0,M), pk(1,0,0,0,M));
    step("R10 response code 3", R, 1, 0, 2'd3, 0, 0, pk(1,0,0,0,M), pk(1,0,0,0,M));
    step("R10 snoop code 5", N, 1, 0, 0, 0, 3'd5, pk(1,0,0,0,M), pk(1,0,0,0,M));
    step("R10 read resp on M", R, 1, 0, 2'd0, 0, 0, pk(1,0,0,0,M), pk(1,0,0,0,M));
    step("R10 snoop upgrade on M", N, 1, 0, 0, 0, 3'd2, pk(1,0,0,0,M), pk(1,0,0,0,M));
    step("R10 R3 state kept after illegal", L, 1, 2'd0, 0, 0, 0, pk(0,0,0,0,M), pk(0,0,0,0,M));
  endtask

  task automatic t_priority;
    step("R11 snoop beats local", L | N, 1, 2'd1, 0, 0, 3'd0, pk(0,0,1,0,O), pk(0,0,1,0,S));
    step("R11 response beats local", L | R, 0, 2'd1, 2'd1, 0, 0, pk(0,0,0,0,M), pk(0,0,0,0,M));
    step("R11 snoop beats response", R | N, 0, 0, 2'd0, 0, 3'd1, pk(0,0,1,0,I), pk(0,0,1,0,I));
    @(negedge clk);
    check("R11 idle quiet", "moesi", {3'b000, ill_a, shr_a, sup_a, bus_a}, 8'h00);
    check("R11 idle quiet", "msi",   {3'b000, ill_b, shr_b, sup_b, bus_b}, 8'h00);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired before the run completed");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_miss_fill();
    t_hits();
    t_dirty_snoop();
    t_clean_snoop();
    t_owned();
    t_invalidate();
    t_illegal();
    t_priority();
    finish_run();
  end
endmodule